// File: doc/BRIEF.md
# DRAM Refresh Pointer and Strobe Sequencer

This block issues DRAM refresh cycles in the refresh slots that an external arbiter grants. It does not keep a row-only counter. It keeps a full 20-bit DMA-style address pointer. In each granted slot the pointer is split into a row part and a column part. The row part goes out on a 10-bit multiplexed address bus first, and the column part follows. The row and column strobes then carry out the refresh. No data moves during a slot, and the DRAM ignores the column address.

A two-bit mode input selects the refresh scheme:
- **Narrow row-only mode.** The pointer steps by one after each slot, and the row wraps after 256.
- **Wide row-only mode.** The pointer steps by 0x100. The pointer-to-address wiring differs from the narrow mode, so each step still moves the row by one, and the row wraps after 512.
- **CAS-before-RAS mode.** The DRAM counts its own rows. The pointer is kept but never stepped.

A 16-bit test write port can overwrite the whole pointer. In the wider modes some register bits feed two pointer bits each.

Top module: `dram_refresh_seq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the pointer is zero. While idle, addr is 0, ras_n and cas_n are 1, and busy is 0.
- R2: A refresh_slot sampled while idle (in a row-only mode, with no write) starts a four-cycle sequence, and busy is 1 in all four cycles. The cycles are: row address with ras_n high; row address with ras_n low for two cycles; column address with ras_n high. cas_n stays 1 throughout.
- R3: In narrow mode (mode 2'b00), the row is {2'b00, ptr[7:0]} and the column is ptr[17:8]. The pointer increases by 1 at the edge that ends the column cycle.
- R4: In wide mode (mode 2'b01), the row is {1'b0, ptr[16:8]} and the column is {ptr[18:17], ptr[7:0]}. The pointer increases by 0x100 at the edge that ends the column cycle.
- R5: The row address wraps from 0xFF to 0x00 in narrow mode and from 0x1FF to 0x000 in wide mode.
- R6: In mode 2'b10 or 2'b11, a slot gives one cycle with cas_n low and ras_n high, then two cycles with both low, then idle. addr stays 0 throughout, and the pointer is not changed.
- R7: A write loads ptr = {4'b0000, reg_wdata} in mode 2'b00. In any other mode it loads ptr = {reg_wdata[15:12], reg_wdata}.
- R8: A write and a slot sampled in the same idle cycle perform the write and drop the slot; busy stays 0.
- R9: A write at the edge where an increment is due loads the written value, with no increment.
- R10: A refresh_slot sampled while busy is ignored.
- R11: The pointer wraps modulo 2^20 on increment.
- R12: The mode is captured when a slot starts and governs that slot's mapping and step, even if the mode input changes mid-slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_slot | input | 1 | One-cycle refresh grant |
| reg_we | input | 1 | Test register write strobe |
| reg_wdata | input | 16 | Test register write data |
| mode | input | 2 | 00 narrow row-only, 01 wide row-only, 1x CAS-before-RAS |
| addr | output | 10 | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| busy | output | 1 | Refresh sequence in progress |

## Verification
Two pairs of events can land on the same clock edge:
- **Write and slot grant.** The bench raises reg_we and refresh_slot together. It then expects busy to stay low, and the next slot must show the written row.
- **Write and pointer increment.** The bench places a write exactly in the column cycle. The following slot must show the written value, not that value plus one step.

A behavioural reference model also compares addr, ras_n, cas_n and busy on every clock through both collisions.

// File: rtl/rfsh_pkg.sv
// Shared types for the refresh sequencer: mode codes and sequence states.
package rfsh_pkg;

    typedef enum logic [1:0] {
        MODE_ROR8    = 2'b00,
        MODE_ROR9    = 2'b01,
        MODE_CBR     = 2'b10,
        MODE_CBR_ALT = 2'b11
    } rf_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS_A,
        ST_RAS_B,
        ST_COL,
        ST_CAS,
        ST_BOTH_A,
        ST_BOTH_B
    } rf_state_e;

    // Both upper mode codes select CAS-before-RAS refresh.
    function automatic logic is_cbr(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/rfsh_seq.sv
// Strobe sequencer. It accepts a refresh grant only while idle and only when
// no register write happens in the same cycle. It latches the mode for the
// whole slot and steps through the row-only or CAS-before-RAS strobe pattern.
// Assumes refresh_slot is a one-cycle pulse from an external arbiter.
module rfsh_seq
    import rfsh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot,
    input  logic       we,
    input  logic [1:0] mode,
    output logic [1:0] seq_mode,
    output logic       busy,
    output logic       ras_n,
    output logic       cas_n,
    output logic       drive_row,
    output logic       drive_col,
    output logic       inc
);

    rf_state_e state, state_nxt;

    // Next-state selection for the fixed strobe sequences.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (slot && !we) state_nxt = is_cbr(mode) ? ST_CAS : ST_ROW;
            ST_ROW:    state_nxt = ST_RAS_A;
            ST_RAS_A:  state_nxt = ST_RAS_B;
            ST_RAS_B:  state_nxt = ST_COL;
            ST_COL:    state_nxt = ST_IDLE;
            ST_CAS:    state_nxt = ST_BOTH_A;
            ST_BOTH_A: state_nxt = ST_BOTH_B;
            ST_BOTH_B: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // State register and the per-slot mode capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            seq_mode <= MODE_ROR8;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && slot && !we) seq_mode <= mode;
        end
    end

    // Moore decode of strobes, mux selects and the increment request.
    always_comb begin
        busy      = (state != ST_IDLE);
        ras_n     = !(state inside {ST_RAS_A, ST_RAS_B, ST_BOTH_A, ST_BOTH_B});
        cas_n     = !(state inside {ST_CAS, ST_BOTH_A, ST_BOTH_B});
        drive_row = (state inside {ST_ROW, ST_RAS_A, ST_RAS_B});
        drive_col = (state == ST_COL);
        inc       = (state == ST_COL);
    end

endmodule

// File: rtl/rfsh_ptr.sv
// Full-width refresh pointer. A register write loads it; in the wider modes
// the top EXT_W data bits also fill the bits above the register width. An
// increment request otherwise steps it by 1 or by 1<<STEP_SHIFT, depending
// on the latched slot mode. A write always wins over an increment.
module rfsh_ptr
    import rfsh_pkg::*;
#(
    parameter int PTR_W      = 20,
    parameter int REG_W      = 16,
    parameter int STEP_SHIFT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic [1:0]       mode,
    input  logic             inc,
    input  logic [1:0]       seq_mode,
    output logic [PTR_W-1:0] ptr
);

    localparam int EXT_W = PTR_W - REG_W;
    localparam logic [PTR_W-1:0] STEP_WIDE = PTR_W'(1) << STEP_SHIFT;

    logic [PTR_W-1:0] load_val;
    logic [PTR_W-1:0] step;

    // Build the load value; the wide form reuses the top data bits.
    generate
        if (EXT_W > 0) begin : g_ext
            always_comb begin
                if (mode == MODE_ROR8) load_val = {{EXT_W{1'b0}}, wdata};
                else                   load_val = {wdata[REG_W-1 -: EXT_W], wdata};
            end
        end else begin : g_noext
            always_comb load_val = wdata[PTR_W-1:0];
        end
    endgenerate

    // Step size follows the mode captured at the start of the slot.
    always_comb step = (seq_mode == MODE_ROR9) ? STEP_WIDE : PTR_W'(1);

    // Pointer register: reset, write load, or post-slot increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (we)  ptr <= load_val;
        else if (inc) ptr <= ptr + step;
    end

endmodule

// File: rtl/rfsh_addr_map.sv
// Splits the pointer into row and column addresses for the row-only modes.
// The wide wiring takes the row from the bits above WIDE_LSB, so that a
// 1<<WIDE_LSB step advances the row by one. Drives zero when idle or in CBR.
module rfsh_addr_map
    import rfsh_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int ROW_NARROW = 8,
    parameter int ROW_WIDE   = 9,
    parameter int WIDE_LSB   = 8,
    parameter int IN_W       = WIDE_LSB + ROW_WIDE + (ADDR_W - WIDE_LSB)
) (
    input  logic [IN_W-1:0]   ptr,
    input  logic [1:0]        seq_mode,
    input  logic              drive_row,
    input  logic              drive_col,
    output logic [ADDR_W-1:0] addr
);

    localparam int COL_HI_W = ADDR_W - WIDE_LSB;

    logic [ADDR_W-1:0] row_n, col_n, row_w, col_w;

    // Fixed wiring for both row-only variants.
    always_comb begin
        row_n = ADDR_W'(ptr[ROW_NARROW-1:0]);
        col_n = ptr[ROW_NARROW +: ADDR_W];
        row_w = ADDR_W'(ptr[WIDE_LSB +: ROW_WIDE]);
        col_w = {ptr[WIDE_LSB+ROW_WIDE +: COL_HI_W], ptr[WIDE_LSB-1:0]};
    end

    // Output mux: row phase, column phase, or zero.
    always_comb begin
        addr = '0;
        if (seq_mode == MODE_ROR8) begin
            if (drive_row)      addr = row_n;
            else if (drive_col) addr = col_n;
        end else if (seq_mode == MODE_ROR9) begin
            if (drive_row)      addr = row_w;
            else if (drive_col) addr = col_w;
        end
    end

endmodule

// File: rtl/dram_refresh_seq.sv
// Top of the refresh block: pointer, address split and strobe sequencer.
// Assumes slot grants come from an external arbiter and the test register
// write is a single-cycle strobe.
module dram_refresh_seq
    import rfsh_pkg::*;
#(
    parameter int PTR_W  = 20,
    parameter int REG_W  = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_slot,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [1:0]        mode,
    output logic [ADDR_W-1:0] addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              busy
);

    localparam int ROW_NARROW = 8;
    localparam int ROW_WIDE   = 9;
    localparam int WIDE_LSB   = 8;
    localparam int MAP_W      = WIDE_LSB + ROW_WIDE + (ADDR_W - WIDE_LSB);

    logic [PTR_W-1:0] ptr;
    logic [1:0]       seq_mode;
    logic             drive_row, drive_col, inc;

    rfsh_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (refresh_slot),
        .we        (reg_we),
        .mode      (mode),
        .seq_mode  (seq_mode),
        .busy      (busy),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .drive_row (drive_row),
        .drive_col (drive_col),
        .inc       (inc)
    );

    rfsh_ptr #(
        .PTR_W      (PTR_W),
        .REG_W      (REG_W),
        .STEP_SHIFT (WIDE_LSB)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .mode     (mode),
        .inc      (inc),
        .seq_mode (seq_mode),
        .ptr      (ptr)
    );

    rfsh_addr_map #(
        .ADDR_W     (ADDR_W),
        .ROW_NARROW (ROW_NARROW),
        .ROW_WIDE   (ROW_WIDE),
        .WIDE_LSB   (WIDE_LSB),
        .IN_W       (MAP_W)
    ) u_map (
        .ptr       (ptr[MAP_W-1:0]),
        .seq_mode  (seq_mode),
        .drive_row (drive_row),
        .drive_col (drive_col),
        .addr      (addr)
    );

endmodule

// File: rtl/rfsh_checker.sv
// Port-level protocol checks for dram_refresh_seq, attached with bind.
module rfsh_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              refresh_slot,
    input logic              reg_we,
    input logic [1:0]        mode,
    input logic [ADDR_W-1:0] addr,
    input logic              ras_n,
    input logic              cas_n,
    input logic              busy
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ras_n && cas_n && addr == '0));

    a_r2_ror_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && refresh_slot && !reg_we && !mode[1]) |=> (busy && ras_n && cas_n));

    a_r2_ras_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |=> !ras_n);

    a_r2_ras_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n)) |=> ras_n);

    a_r6_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ras_n);

    a_r6_cbr_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && refresh_slot && !reg_we && mode[1]) |=> (!cas_n && ras_n && addr == '0));

    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && refresh_slot && reg_we) |=> !busy);

endmodule

bind dram_refresh_seq rfsh_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .refresh_slot (refresh_slot),
    .reg_we       (reg_we),
    .mode         (mode),
    .addr         (addr),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .busy         (busy)
);

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        refresh_slot = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [1:0]  mode = 2'b00;
    logic [9:0]  addr;
    logic        ras_n, cas_n, busy;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit model_on = 0;

    always #2 clk = ~clk;   // 250 MHz

    dram_refresh_seq dut_i (
        .clk(clk), .rst_n(rst_n), .refresh_slot(refresh_slot), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .mode(mode), .addr(addr), .ras_n(ras_n),
        .cas_n(cas_n), .busy(busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1..4 row-only, 5..7 CBR.
    int m_ptr = 0, m_phase = 0, m_lmode = 0;

    function automatic int load_val(input int d, input int md);
        if (md == 0) return d & 16'hFFFF;
        return (((d >> 12) & 4'hF) << 16) | (d & 16'hFFFF);
    endfunction

    function automatic int exp_addr(input int ph, input int p, input int lm);
        if (ph >= 1 && ph <= 3) return (lm == 0) ? (p & 8'hFF) : ((p >> 8) & 9'h1FF);
        if (ph == 4) return (lm == 0) ? ((p >> 8) & 10'h3FF)
                                      : ((((p >> 17) & 3) << 8) | (p & 8'hFF));
        return 0;
    endfunction

    always @(posedge clk) begin
        int old_phase;
        if (!rst_n) begin
            m_ptr = 0; m_phase = 0; m_lmode = 0; model_on = 1;
        end else begin
            old_phase = m_phase;
            if (reg_we) m_ptr = load_val(int'(reg_wdata), int'(mode));
            else if (old_phase == 4) m_ptr = (m_ptr + ((m_lmode == 1) ? 256 : 1)) & 20'hFFFFF;
            if (old_phase == 0) begin
                if (refresh_slot && !reg_we) begin
                    m_lmode = int'(mode);
                    m_phase = mode[1] ? 5 : 1;
                end
            end else if (old_phase == 4 || old_phase == 7) m_phase = 0;
            else m_phase = old_phase + 1;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_on && rst_n && !finished) begin
            string tag;
            tag = (m_phase == 0) ? "R1 idle" : (m_phase <= 4) ? "R2 ror seq" : "R6 cbr seq";
            check({tag, " addr"}, int'(addr), exp_addr(m_phase, m_ptr, m_lmode));
            check({tag, " ras_n"}, int'(ras_n), (m_phase inside {2, 3, 6, 7}) ? 0 : 1);
            check({tag, " cas_n"}, int'(cas_n), (m_phase inside {5, 6, 7}) ? 0 : 1);
            check({tag, " busy"}, int'(busy), (m_phase != 0) ? 1 : 0);
        end
    end

    task automatic do_write(input logic [1:0] md, input logic [15:0] d);
        @(negedge clk); mode = md; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic ror_slot(output int row, output int col);
        @(negedge clk); refresh_slot = 1'b1;
        @(negedge clk); refresh_slot = 1'b0; row = int'(addr);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); col = int'(addr);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int row, col;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset addr", int'(addr), 0);
        check("R1 reset strobes", int'({ras_n, cas_n}), 3);
        check("R1 reset busy", int'(busy), 0);

        // R3: narrow mapping and +1 step from zero.
        ror_slot(row, col);
        check("R3 first row", row, 0);
        check("R3 first col", col, 0);
        ror_slot(row, col);
        check("R3 row after step", row, 1);

        // R7 narrow load, R5 narrow row wrap.
        do_write(2'b00, 16'h12FF);
        ror_slot(row, col);
        check("R7 narrow load row", row, 'hFF);
        check("R3 narrow col", col, 'h12);
        ror_slot(row, col);
        check("R5 narrow row wrap", row, 'h00);
        check("R5 narrow col carry", col, 'h13);

        // R4 wide mapping, R7 wide load duplicating the top nibble.
        do_write(2'b01, 16'hABCD);
        ror_slot(row, col);
        check("R4 wide row", row, 'h0AB);
        check("R7 wide col", col, 'h1CD);
        ror_slot(row, col);
        check("R4 wide row step", row, 'h0AC);

        // R5 wide row wrap and R11 pointer wrap at 2^20.
        do_write(2'b01, 16'hFF00);
        ror_slot(row, col);
        check("R5 wide row top", row, 'h1FF);
        ror_slot(row, col);
        check("R11 ptr wrap row", row, 0);
        check("R11 ptr wrap col", col, 0);

        // R6: CBR strobes, zero address, pointer unchanged.
        do_write(2'b10, 16'h0005);
        @(negedge clk); refresh_slot = 1'b1;
        @(negedge clk); refresh_slot = 1'b0;
        check("R6 cas first", int'({cas_n, ras_n}), 1);
        @(negedge clk);
        check("R6 both low", int'({cas_n, ras_n}), 0);
        @(negedge clk);
        check("R6 both low 2", int'({cas_n, ras_n}), 0);
        check("R6 addr zero", int'(addr), 0);
        @(negedge clk);
        check("R6 back idle", int'(busy), 0);
        mode = 2'b11;
        @(negedge clk); refresh_slot = 1'b1;
        @(negedge clk); refresh_slot = 1'b0;
        check("R6 alt code cas", int'({cas_n, ras_n}), 1);
        repeat (3) @(negedge clk);
        mode = 2'b00;
        ror_slot(row, col);
        check("R6 ptr not stepped", row, 5);

        // R8: write and slot in the same cycle.
        @(negedge clk); reg_we = 1'b1; reg_wdata = 16'h0040; refresh_slot = 1'b1;
        @(negedge clk); reg_we = 1'b0; refresh_slot = 1'b0;
        check("R8 slot dropped", int'(busy), 0);
        ror_slot(row, col);
        check("R8 write taken", row, 'h40);

        // R9: write on the increment edge.
        @(negedge clk); refresh_slot = 1'b1;
        @(negedge clk); refresh_slot = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); reg_we = 1'b1; reg_wdata = 16'h0077;
        @(negedge clk); reg_we = 1'b0;
        ror_slot(row, col);
        check("R9 no increment", row, 'h77);

        // R10: slot during busy ignored (pointer now 0x78).
        @(negedge clk); refresh_slot = 1'b1;
        @(negedge clk); refresh_slot = 1'b0;
        @(negedge clk); refresh_slot = 1'b1;
        @(negedge clk); refresh_slot = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 no restart", int'(busy), 0);
        ror_slot(row, col);
        check("R10 single step", row, 'h79);

        // R12: mode change mid-slot keeps narrow mapping and step.
        do_write(2'b00, 16'h3456);
        @(negedge clk); refresh_slot = 1'b1;
        @(negedge clk); refresh_slot = 1'b0;
        @(negedge clk); mode = 2'b01;
        @(negedge clk);
        @(negedge clk); col = int'(addr);
        check("R12 latched col", col, 'h034);
        @(negedge clk); mode = 2'b00;
        ror_slot(row, col);
        check("R12 latched step", row, 'h57);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule